// File: doc/BRIEF.md
# Flash Toggle Status Generator

This block sits on the read path of a parallel NOR flash. It produces the two toggle status bits that a host polls while an embedded program or erase runs. Bit 6 of the read word is a device-wide toggle. It flips on every new read access while an operation is running, and it freezes while an erase is suspended. Bit 2 is a per-sector toggle. It flips only on reads whose address lands in a sector that is really being erased, whether that erase is running or suspended. Every other bit of the read word passes straight through from the array data input. The polling bits that belong to other blocks are merged there.

The algorithm controller reports four things: the start of each operation, a busy flag, an erase-active flag and an erase-suspended flag. It also supplies the erase selection mask and the sector protection mask. Some operations can do nothing because their targets are protected. An erase whose selected sectors are all protected, or a program aimed at a protected sector, is one of these. For such an operation the block opens a timed window of its own, in which bit 6 toggles. When the window ends, reads return array data again. The sector of a read is taken from the top address bits. A read access begins when chip enable and output enable are both low after either one was high.

Top module: `flash_toggle_status`

## Requirements
- R1: With busy, erase-active and erase-suspended all low and no protected-operation window open, rd_data_o equals array_data_i.
- R2: While busy_i is high, bit 6 of rd_data_o inverts once per new read access. The new value is visible from the cycle after the access begins.
- R3: A read held with ce_n_i and oe_n_i both low does not advance either toggle bit, however long it lasts.
- R4: With busy_i low and erase_susp_i high, bit 6 holds its value. Bit 2 still toggles on reads of selected sectors. Reads of unselected sectors return array_data_i. If busy_i rises during the suspend (a program inside the suspend), bit 6 toggles again.
- R5: Bit 2 inverts on a new read access only when erase_act_i or erase_susp_i is high and the read sector (top log2(NUM_SECTORS) address bits) is selected and unprotected. Reads of other sectors leave it unchanged.
- R6: A sector that is both selected and protected is treated as not selected. Reads of it do not toggle bit 2. It does not count toward starting an erase.
- R7: op_start_i clears both toggle bits to 0. This takes priority over a read access that begins in the same cycle.
- R8: An erase start whose unprotected selection is empty opens a window of PROT_ERASE_CYCLES cycles. During the window reads show status and bit 6 toggles. Afterwards they return array data.
- R9: A program start whose target sector op_sector_i is protected opens a window of PROT_PROG_CYCLES cycles, with the same read behaviour as R8.
- R10: In status mode, every bit other than 6 and 2 equals the matching bit of array_data_i.
- R11: After reset both toggle bits are 0 and no window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start_i | input | 1 | One-cycle pulse at the final write of a program or erase command |
| op_erase_i | input | 1 | Operation kind at op_start_i: 1 erase, 0 program |
| op_sector_i | input | log2(NUM_SECTORS) | Target sector of a program |
| busy_i | input | 1 | Embedded algorithm running (includes erase time-out and program in suspend) |
| erase_act_i | input | 1 | Erase in progress |
| erase_susp_i | input | 1 | Erase suspended |
| erase_sel_i | input | NUM_SECTORS | Sectors selected for erase |
| sector_prot_i | input | NUM_SECTORS | Sector protection flags |
| rd_addr_i | input | ADDR_W | Read address |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| array_data_i | input | DATA_W | Data read from the array |
| rd_data_o | output | DATA_W | Read word with status bits inserted |

## Verification
Two events can meet in a single clock edge: the start of a new operation, which clears the toggles, and the start of a read access, which advances them. The bench provokes this by raising op_start_i in the same cycle that ce_n_i and oe_n_i fall, after a previous read has left bit 6 at 1. A correct design reads back 0, not 1. A second meeting point is a read that begins in the last cycle of a protected-operation window. The bench's cycle model decides whether that read still toggles, and the design's word is compared with the model on every clock.

// File: rtl/flash_toggle_status.sv
module flash_toggle_status #(
  parameter int NUM_SECTORS       = 16,
  parameter int ADDR_W            = 20,
  parameter int DATA_W            = 8,
  parameter int PROT_ERASE_CYCLES = 200000,
  parameter int PROT_PROG_CYCLES  = 200
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   op_start_i,
  input  logic                   op_erase_i,
  input  logic [$clog2(NUM_SECTORS)-1:0] op_sector_i,
  input  logic                   busy_i,
  input  logic                   erase_act_i,
  input  logic                   erase_susp_i,
  input  logic [NUM_SECTORS-1:0] erase_sel_i,
  input  logic [NUM_SECTORS-1:0] sector_prot_i,
  input  logic [ADDR_W-1:0]      rd_addr_i,
  input  logic                   ce_n_i,
  input  logic                   oe_n_i,
  input  logic [DATA_W-1:0]      array_data_i,
  output logic [DATA_W-1:0]      rd_data_o
);
  localparam int SEC_W = $clog2(NUM_SECTORS);
  localparam int CNT_W = $clog2(PROT_ERASE_CYCLES + 1);

  logic                   rd_act, rd_act_q, rd_start;
  logic [SEC_W-1:0]       rd_sec;
  logic [NUM_SECTORS-1:0] eff_sel;
  logic                   sec_hit, win_act, status_mode;
  logic [CNT_W-1:0]       win_cnt, win_load;
  logic                   tog6, tog2;

  assign rd_act   = !ce_n_i && !oe_n_i;
  assign rd_start = rd_act && !rd_act_q;
  assign rd_sec   = rd_addr_i[ADDR_W-1 -: SEC_W];
  assign eff_sel  = erase_sel_i & ~sector_prot_i;
  assign sec_hit  = eff_sel[rd_sec];
  assign win_act  = (win_cnt != '0);

  always_comb begin
    win_load = '0;
    if (op_erase_i) begin
      if (eff_sel == '0) win_load = CNT_W'(PROT_ERASE_CYCLES);
    end else if (sector_prot_i[op_sector_i]) begin
      win_load = CNT_W'(PROT_PROG_CYCLES);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act_q <= 1'b0;
      win_cnt  <= '0;
      tog6     <= 1'b0;
      tog2     <= 1'b0;
    end else begin
      rd_act_q <= rd_act;
      if (op_start_i) begin
        win_cnt <= win_load;
        tog6    <= 1'b0;
        tog2    <= 1'b0;
      end else begin
        if (win_act) win_cnt <= win_cnt - 1'b1;
        if (rd_start && (busy_i || win_act)) tog6 <= !tog6;
        if (rd_start && (erase_act_i || erase_susp_i) && sec_hit) tog2 <= !tog2;
      end
    end
  end

  assign status_mode = busy_i || win_act || ((erase_act_i || erase_susp_i) && sec_hit);

  always_comb begin
    rd_data_o = array_data_i;
    if (status_mode) begin
      rd_data_o[6] = tog6;
      rd_data_o[2] = tog2;
    end
  end

  assert_idle_passthrough_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i && !erase_act_i && !erase_susp_i && !win_act) |-> (rd_data_o == array_data_i));

  assert_held_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n_i && !oe_n_i && $past(!ce_n_i && !oe_n_i) && !op_start_i) |=> ($stable(tog6) && $stable(tog2)));

  assert_suspend_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i && !win_act && !op_start_i) |=> $stable(tog6));

  assert_protected_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sector_prot_i[rd_sec] && !op_start_i) |=> $stable(tog2));

  assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    op_start_i |=> (!tog6 && !tog2));

  assert_window_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (win_cnt <= CNT_W'(PROT_ERASE_CYCLES)));
endmodule

// File: tb/tb_flash_toggle_status.sv
`timescale 1ns/1ps
module tb_flash_toggle_status;
  localparam int NS = 8, AW = 12, DW = 8, PE = 40, PP = 10;

  logic clk = 0, rst_n = 0;
  logic op_start = 0, op_erase = 0;
  logic [2:0] op_sector = 0;
  logic busy = 0, erase_act = 0, erase_susp = 0;
  logic [NS-1:0] erase_sel = 0, prot = 0;
  logic [AW-1:0] rd_addr = 0;
  logic ce_n = 1, oe_n = 1;
  logic [DW-1:0] arr = 8'h44;
  logic [DW-1:0] rd_data;

  int checks = 0, failures = 0;
  bit cmp_en = 0, done = 0;
  string phase = "R11";

  flash_toggle_status #(.NUM_SECTORS(NS), .ADDR_W(AW), .DATA_W(DW),
    .PROT_ERASE_CYCLES(PE), .PROT_PROG_CYCLES(PP)) dut (
    .clk(clk), .rst_n(rst_n), .op_start_i(op_start), .op_erase_i(op_erase),
    .op_sector_i(op_sector), .busy_i(busy), .erase_act_i(erase_act),
    .erase_susp_i(erase_susp), .erase_sel_i(erase_sel), .sector_prot_i(prot),
    .rd_addr_i(rd_addr), .ce_n_i(ce_n), .oe_n_i(oe_n), .array_data_i(arr),
    .rd_data_o(rd_data));

  always #2.5 clk = ~clk;

  bit m6 = 0, m2 = 0, mrdq = 0;
  int mcnt = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m6 = 0; m2 = 0; mrdq = 0; mcnt = 0;
    end else begin
      bit ract, rs;
      int sec;
      logic [NS-1:0] eff;
      ract = !ce_n && !oe_n;
      rs = ract && !mrdq;
      sec = int'(rd_addr >> (AW - 3));
      eff = erase_sel & ~prot;
      if (op_start) begin
        m6 = 0; m2 = 0;
        if (op_erase) mcnt = (eff == 0) ? PE : 0;
        else mcnt = prot[op_sector] ? PP : 0;
      end else begin
        if (rs && (busy || mcnt > 0)) m6 = !m6;
        if (rs && (erase_act || erase_susp) && eff[sec]) m2 = !m2;
        if (mcnt > 0) mcnt--;
      end
      mrdq = ract;
    end
  end

  function automatic logic [DW-1:0] model_word();
    int sec;
    logic [NS-1:0] eff;
    logic [DW-1:0] w;
    sec = int'(rd_addr >> (AW - 3));
    eff = erase_sel & ~prot;
    w = arr;
    if (busy || mcnt > 0 || ((erase_act || erase_susp) && eff[sec])) begin
      w[6] = m6; w[2] = m2;
    end
    return w;
  endfunction

  always @(negedge clk) if (cmp_en && !done) begin
    logic [DW-1:0] e;
    e = model_word();
    checks++;
    if (rd_data !== e) begin
      failures++;
      $display("FAIL %s cycle model: actual=%h expected=%h", phase, rd_data, e);
    end
  end

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic rd(input int sec, output logic [DW-1:0] v);
    rd_addr = AW'(sec << (AW - 3));
    ce_n = 0; oe_n = 0;
    tick(); tick();
    v = rd_data;
    oe_n = 1;
    tick();
  endtask

  task automatic start_op(bit er, int sec);
    op_erase = er; op_sector = 3'(sec); op_start = 1;
    tick();
    op_start = 0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v, v0;
    cmp_en = 1;
    tick(); tick();
    rst_n = 1;
    tick();
    chk("R11 reset/R1 idle", rd_data, 8'h44);

    phase = "R2"; arr = 8'h00; busy = 1;
    start_op(0, 1);
    rd(1, v); chk("R2 first read bit6", v & 8'h40, 8'h40);
    rd(1, v); chk("R2 second read bit6", v & 8'h40, 8'h00);
    phase = "R10"; arr = 8'hBB;
    rd(4, v); chk("R10 other bits", v, 8'hFB);

    phase = "R3";
    rd_addr = 0; ce_n = 0; oe_n = 0;
    tick(); tick(); v0 = rd_data;
    repeat (10) tick();
    chk("R3 held read", rd_data, v0);
    oe_n = 1; tick();

    phase = "R1"; busy = 0;
    tick(); chk("R1 after op", rd_data, 8'hBB);

    phase = "R5"; arr = 8'h00;
    erase_sel = 8'b0000_0110; prot = 8'b0000_0100;
    busy = 1; erase_act = 1;
    start_op(1, 0);
    rd(1, v); chk("R5 selected sector", v, 8'h44);
    phase = "R6";
    rd(2, v); chk("R6 protected selected sector", v, 8'h04);
    phase = "R5";
    rd(5, v); chk("R5 unselected sector", v, 8'h44);

    phase = "R4"; busy = 0; erase_act = 0; erase_susp = 1;
    rd(1, v); chk("R4 suspend dq6 frozen dq2 toggles", v, 8'h40);
    rd(1, v); chk("R4 suspend second read", v, 8'h44);
    arr = 8'h5A;
    rd(5, v); chk("R4 unselected reads array", v, 8'h5A);
    arr = 8'h00; busy = 1;
    rd(5, v); chk("R4 program in suspend toggles", v, 8'h04);
    busy = 0; erase_susp = 0; erase_sel = 0; prot = 0;
    tick();

    phase = "R7"; busy = 1;
    start_op(0, 1);
    rd(1, v); chk("R7 pre read", v, 8'h40);
    op_erase = 0; op_sector = 1; op_start = 1; ce_n = 0; oe_n = 0;
    tick(); op_start = 0; tick();
    chk("R7 clear beats read start", rd_data, 8'h00);
    oe_n = 1; busy = 0; tick();

    phase = "R8"; arr = 8'h00;
    erase_sel = 8'b0001_1000; prot = 8'b0001_1000;
    start_op(1, 0);
    rd(0, v); chk("R8 window status", v, 8'h40);
    rd(0, v); chk("R8 window toggles", v, 8'h00);
    arr = 8'h66;
    repeat (PE - 9) tick();
    rd_addr = 0; ce_n = 0; oe_n = 0; tick(); tick(); oe_n = 1; tick();
    repeat (4) tick();
    rd(0, v); chk("R8 after window", v, 8'h66);
    erase_sel = 0;

    phase = "R9"; prot = 8'b0000_1000; arr = 8'h00;
    start_op(0, 3);
    rd(0, v); chk("R9 window status", v, 8'h40);
    arr = 8'h99;
    repeat (PP + 2) tick();
    rd(0, v); chk("R9 after window", v, 8'h99);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule